// File: doc/BRIEF.md
# Calibrated One-Second Divider

This block divides an oscillator enable strobe down to a one-second tick and a minute tick. In the default build one second is 32,768 strobes, split into a 256-strobe prescaler and a 128-step stage counter. Clock cycles that carry no strobe do not move any counter. A signed trim value, `cal_i`, corrects the long-term rate. It does this by changing the length of whole seconds, not by dividing by a fraction.

The correction repeats over a 64-minute cycle. When the trim magnitude is N, the first second of each of the first 2N minutes in the cycle is changed. A speed-up second is shortened by half a prescaler period (128 strobes). A slow-down second is lengthened by one extra stage (256 strobes). The trim value is sampled on the first strobe of every minute, so a change written later in a minute first applies to the next minute. The second and minute counters that track the cycle are inside the block.

Top module: `rtc_cal_divider`

## Requirements
- R1: An unmodified second spans exactly PRE_DIV*STAGES strobes (default 32,768). Clock cycles with `osc_en_i` low do not advance the divider.
- R2: `sec_tick_o` is high for one clock cycle, the cycle after the clock edge that consumed the last strobe of a second.
- R3: `min_tick_o` pulses together with every SEC_PER_MIN-th second tick (default 60) and at no other time.
- R4: `cal_i[4:0]` is the unsigned trim magnitude N (0 to 31). `cal_i[5]` is the sign: 1 speeds the clock up and 0 slows it down.
- R5: A second modified with sign 1 is shortened by PRE_DIV/2 strobes (default 128).
- R6: A second modified with sign 0 is lengthened by PRE_DIV strobes (default 256).
- R7: Minutes are numbered 0 to 63 within a repeating cycle. Only second 0 of a minute m with m < 2N (and m < 62) is modified. All other seconds have the nominal length.
- R8: N = 0 leaves every second at the nominal length, whatever the sign bit is.
- R9: `cal_i` is sampled on the first strobe of each minute. A value written after that strobe has no effect until the next minute.
- R10: Reset clears all counters and drives both ticks low. The first minute after reset is minute 0 of the cycle.
- R11: Over one full 64-minute cycle the total strobe count differs from nominal by -N*PRE_DIV for sign 1 and by +2N*PRE_DIV for sign 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | One-cycle strobe per oscillator period |
| cal_i | input | 6 | Trim value: bit 5 sign, bits 4:0 magnitude |
| sec_tick_o | output | 1 | One-cycle pulse at the end of each second |
| min_tick_o | output | 1 | One-cycle pulse at the end of each minute |

## Verification
The assertions assume that `cal_i` is synchronous to `clk_i`, that PRE_DIV is even and that STAGES is at least 2. With those assumptions, a shortened stage always starts with the prescaler at zero, and the trim decision never changes part way through a second. The bench shrinks the divider (4 x 4 strobes, four seconds per minute) so that five full 64-minute cycles fit in the run. It drives the strobe with an irregular gap pattern. It writes `cal_i` one cycle after a clock edge and only once the first strobe of a minute has been consumed, so each write lands at a known point that falls in the middle of a minute.

// File: rtl/rtccal_pkg.sv
package rtccal_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE  = 2'd0,
    TRIM_SHORT = 2'd1,
    TRIM_LONG  = 2'd2
  } trim_e;
endpackage

// File: rtl/rtccal_prescaler.sv
module rtccal_prescaler #(
  parameter int PRE_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic short_i,
  output logic zero_o,
  output logic last_o
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] FULL_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [PRE_W-1:0] HALF_LAST = PRE_W'(PRE_DIV / 2 - 1);

  logic [PRE_W-1:0] pre_cnt;

  assign zero_o = (pre_cnt == '0);
  assign last_o = (pre_cnt == (short_i ? HALF_LAST : FULL_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_cnt <= '0;
    else if (osc_en_i) pre_cnt <= last_o ? '0 : pre_cnt + 1'b1;
  end

  // R5
  short_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_i |-> (pre_cnt <= HALF_LAST));
endmodule

// File: rtl/rtccal_stage_ctr.sv
module rtccal_stage_ctr #(
  parameter int STAGES = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic extend_i,
  output logic zero_o,
  output logic final_o,
  output logic sec_end_o
);
  localparam int STG_W = $clog2(STAGES + 1);
  localparam logic [STG_W-1:0] NORM_LAST = STG_W'(STAGES - 1);
  localparam logic [STG_W-1:0] EXT_LAST  = STG_W'(STAGES);

  logic [STG_W-1:0] stg_cnt;

  assign zero_o    = (stg_cnt == '0);
  assign final_o   = (stg_cnt == NORM_LAST);
  assign sec_end_o = step_i && (stg_cnt == (extend_i ? EXT_LAST : NORM_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stg_cnt <= '0;
    else if (sec_end_o) stg_cnt <= '0;
    else if (step_i)    stg_cnt <= stg_cnt + 1'b1;
  end

  // R6
  stage_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!extend_i) |-> (stg_cnt <= NORM_LAST));
endmodule

// File: rtl/rtccal_tracker.sv
module rtccal_tracker #(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  localparam int SEC_W = $clog2(SEC_PER_MIN),
  localparam int MIN_W = $clog2(MIN_PER_CYCLE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [SEC_W-1:0] sec_idx_o,
  output logic [MIN_W-1:0] min_idx_o,
  output logic             min_end_o
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);

  assign min_end_o = step_i && (sec_idx_o == SEC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_idx_o <= '0;
      min_idx_o <= '0;
    end else if (step_i) begin
      sec_idx_o <= min_end_o ? '0 : sec_idx_o + 1'b1;
      if (min_end_o) min_idx_o <= (min_idx_o == MIN_LAST) ? '0 : min_idx_o + 1'b1;
    end
  end

  // R3
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && sec_idx_o == SEC_LAST) |=> (sec_idx_o == '0));
  // R7
  min_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_end_o && min_idx_o == MIN_LAST) |=> (min_idx_o == '0));
endmodule

// File: rtl/rtccal_trim_ctl.sv
module rtccal_trim_ctl
  import rtccal_pkg::*;
#(
  parameter int SEC_W       = 6,
  parameter int MIN_W       = 6,
  parameter int MOD_MINUTES = 62
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [5:0]       cal_i,
  input  logic [SEC_W-1:0] sec_idx_i,
  input  logic [MIN_W-1:0] min_idx_i,
  output trim_e            trim_o
);
  logic [5:0] cal_q;
  logic       in_window;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cal_q <= '0;
    else if (capture_i) cal_q <= cal_i;
  end

  always_comb begin
    in_window = (sec_idx_i == '0) && (cal_q[4:0] != '0)
             && (int'(min_idx_i) < 2 * int'(cal_q[4:0]))
             && (int'(min_idx_i) < MOD_MINUTES);
    if (!in_window)    trim_o = TRIM_NONE;
    else if (cal_q[5]) trim_o = TRIM_SHORT;
    else               trim_o = TRIM_LONG;
  end

  // R7
  first_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_o != TRIM_NONE) |-> (sec_idx_i == '0));
  // R8
  zero_mag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_q[4:0] == '0) |-> (trim_o == TRIM_NONE));
  // R9
  sample_point_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cal_q)) |-> ($past(capture_i) && $past(sec_idx_i) == '0));
endmodule

// File: rtl/rtc_cal_divider.sv
module rtc_cal_divider
  import rtccal_pkg::*;
#(
  parameter int PRE_DIV       = 256,
  parameter int STAGES        = 128,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int MOD_MINUTES   = 62
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_en_i,
  input  logic [5:0] cal_i,
  output logic       sec_tick_o,
  output logic       min_tick_o
);
  localparam int SEC_W = $clog2(SEC_PER_MIN);
  localparam int MIN_W = $clog2(MIN_PER_CYCLE);

  logic             pre_zero, pre_last, stg_zero, stg_final;
  logic             sec_end, min_end, short_en;
  logic [SEC_W-1:0] sec_idx;
  logic [MIN_W-1:0] min_idx;
  trim_e            trim;

  assign short_en = (trim == TRIM_SHORT) && stg_final;

  rtccal_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i, .rst_ni, .osc_en_i,
    .short_i(short_en), .zero_o(pre_zero), .last_o(pre_last)
  );

  rtccal_stage_ctr #(.STAGES(STAGES)) u_stg (
    .clk_i, .rst_ni,
    .step_i(osc_en_i && pre_last), .extend_i(trim == TRIM_LONG),
    .zero_o(stg_zero), .final_o(stg_final), .sec_end_o(sec_end)
  );

  rtccal_tracker #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE)) u_trk (
    .clk_i, .rst_ni, .step_i(sec_end),
    .sec_idx_o(sec_idx), .min_idx_o(min_idx), .min_end_o(min_end)
  );

  // first strobe of second 0 latches the trim for the whole minute
  rtccal_trim_ctl #(.SEC_W(SEC_W), .MIN_W(MIN_W), .MOD_MINUTES(MOD_MINUTES)) u_trim (
    .clk_i, .rst_ni,
    .capture_i(osc_en_i && pre_zero && stg_zero && sec_idx == '0),
    .cal_i, .sec_idx_i(sec_idx), .min_idx_i(min_idx), .trim_o(trim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_tick_o <= 1'b0;
      min_tick_o <= 1'b0;
    end else begin
      sec_tick_o <= sec_end;
      min_tick_o <= min_end;
    end
  end

  // R3
  min_with_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_tick_o |-> sec_tick_o);
  // R2
  tick_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);
endmodule

// File: tb/rtc_cal_divider_test.sv
module rtc_cal_divider_test;
  localparam int PRE_DIV = 4, STAGES = 4, SPM = 4, MPC = 64;
  localparam int NOM = PRE_DIV * STAGES;
  localparam int TOTAL_MIN = 324;

  logic clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0;
  logic [5:0] cal = 6'h26;
  logic sec_tick, min_tick;

  always #2 clk = ~clk;

  rtc_cal_divider #(.PRE_DIV(PRE_DIV), .STAGES(STAGES), .SEC_PER_MIN(SPM),
                    .MIN_PER_CYCLE(MPC), .MOD_MINUTES(62)) uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .cal_i(cal),
    .sec_tick_o(sec_tick), .min_tick_o(min_tick)
  );

  typedef struct { int len; int g; int s; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0;
  int min_seen = 0, sec_seen = 0, strobe_cnt = 0, cyc_sum = 0;
  bit done = 1'b0, prev_tick = 1'b0;

  // value in force for global minute g (writes land mid-minute)
  function automatic logic [5:0] eff_cal(int g);
    if (g <= 63)  return 6'h26;
    if (g <= 127) return 6'h03;
    if (g <= 191) return 6'h3F;
    if (g <= 255) return 6'h20;
    if (g <= 320) return 6'h1F;
    return 6'h22;
  endfunction

  function automatic int exp_len(int g, int s);
    logic [5:0] c = eff_cal(g);
    int n = int'(c[4:0]);
    if (s == 0 && n != 0 && (g % MPC) < 2 * n && (g % MPC) < 62)
      return c[5] ? NOM - PRE_DIV / 2 : NOM + PRE_DIV;
    return NOM;
  endfunction

  function automatic string tag_of(int g, int s, int len);
    if (g == 320 || g == 321) return "R9";
    if (g == 0 && s == 0)     return "R10";
    if (eff_cal(g)[4:0] == 0) return "R8";
    if (len < NOM)            return "R5";
    if (len > NOM)            return "R6";
    if (s == 0)               return "R7";
    return "R1";
  endfunction

  task automatic push_expected();
    for (int g = 0; g < TOTAL_MIN; g++)
      for (int s = 0; s < SPM; s++) begin
        item_t it;
        it.len = exp_len(g, s); it.g = g; it.s = s;
        exp_q.push_back(it);
      end
  endtask

  task automatic write_at(int g, logic [5:0] v);
    wait (min_seen == g);
    wait (strobe_cnt >= 3);
    @(posedge clk); #1 cal = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sec_tick) begin
        item_t it;
        int dev, want, n;
        logic [5:0] c;
        checks++;
        if (prev_tick) begin
          fails++; $display("FAIL R2 tick width: actual 2+ cycles expected 1");
        end
        if (exp_q.size() == 0) begin
          fails++; $display("FAIL R1 extra second: actual tick expected none");
        end else begin
          it = exp_q.pop_front();
          checks++;
          if (strobe_cnt != it.len) begin
            fails++;
            $display("FAIL %s min %0d sec %0d length: actual %0d expected %0d",
                     tag_of(it.g, it.s, it.len), it.g, it.s, strobe_cnt, it.len);
          end
        end
        checks++;
        if (min_tick != ((sec_seen % SPM) == SPM - 1)) begin
          fails++;
          $display("FAIL R3 minute tick at second %0d: actual %0b expected %0b",
                   sec_seen, min_tick, (sec_seen % SPM) == SPM - 1);
        end
        cyc_sum += strobe_cnt;
        strobe_cnt = 0;
        sec_seen++;
        if (min_tick) min_seen++;
        if (sec_seen % (MPC * SPM) == 0) begin
          c = eff_cal((sec_seen / (MPC * SPM) - 1) * MPC);
          n = int'(c[4:0]);
          want = (n == 0) ? 0 : (c[5] ? -n * PRE_DIV : 2 * n * PRE_DIV);
          dev = cyc_sum - NOM * MPC * SPM;
          checks++;
          if (dev != want) begin
            fails++;
            $display("FAIL R11 R4 cycle deviation cal %h: actual %0d expected %0d", c, dev, want);
          end
          cyc_sum = 0;
        end
        if (sec_seen == TOTAL_MIN * SPM) done = 1'b1;
      end else if (min_tick) begin
        checks++; fails++;
        $display("FAIL R3 minute tick without second tick: actual 1 expected 0");
      end
      prev_tick = sec_tick;
      if (osc_en) strobe_cnt++;
    end
  end

  // strobe driver with irregular gaps (R1)
  initial begin
    wait (rst_n);
    for (int k = 0; ; k++) begin
      @(posedge clk); #1;
      osc_en = !done && (k % 7 != 2) && (k % 11 != 5);
    end
  end

  // trim writer: each write falls after the first strobe of its minute
  initial begin
    wait (rst_n);
    write_at(63, 6'h03);
    write_at(127, 6'h3F);
    write_at(191, 6'h20);
    write_at(255, 6'h1F);
    write_at(320, 6'h22);
  end

  initial begin
    push_expected();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sec_tick !== 1'b0 || min_tick !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset outputs: actual %b%b expected 00", sec_tick, min_tick);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    wait (done);
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R1 missing seconds: actual %0d left expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual %0d seconds expected %0d", sec_seen, TOTAL_MIN * SPM);
      summary();
      $finish;
    end
  end
endmodule